// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing core of a two-output pulse-width modulator. It divides the system clock with a two-stage prescaler into a one-cycle tick enable, and on each tick steps a 16-bit count in one of four modes: counting up, counting down, counting up then down, or frozen. It reports the count, the direction of the last step, and one-cycle strobes when the count lands on zero or on the period value. Compare and output-action stages downstream use these outputs. They are not part of this block.

Software writes two registers through a single write port. The control register holds the counting mode, the period-load policy, the two prescaler fields and the run field. The period register is written either to a shadow copy, which becomes active when the count lands on zero, or straight to the active copy. Everything runs in the one input clock domain. The tick is an enable, not a derived clock.

Top module: `pwm_timebase`

## Requirements
- R1: After a synchronous active-low reset, the count is 0, both strobes and the direction output are low, and the counter does not step, because the cleared run field stops it.
- R2: The tick repeats every 2^A x D system clocks. A is the control field at bits 12:10. D is 1 when the field at bits 9:7 (B) is zero, and 2 x B otherwise.
- R3: When mode bits 1:0 are 00, the count goes 0, 1, ... P and then back to 0, with P the active period. The direction output is low. The zero strobe is high for one clock when a step lands on 0. The period strobe is high for one clock when a step lands on P.
- R4: When mode bits 1:0 are 01, the count goes P, P-1, ... 0 and then back to P. The direction output is high, and the strobes follow the same landing rule as in R3.
- R5: When mode bits 1:0 are 10, the count rises from 0 to P and then falls back to 0. The direction output is high exactly when the last step went down, which includes the step that lands on 0.
- R6: When mode bits 1:0 are 11, the count holds and no strobe is raised.
- R7: When run bits 15:14 are 00, the counter takes no step at any tick after the write is registered.
- R8: When run bits 15:14 are 01, the counter keeps stepping until it lands on 0, then holds at 0.
- R9: When run bit 15 is set, the counter steps on every tick without stopping.
- R10: When control bit 3 is 0, a period write goes to the shadow copy. The active period keeps its old value until the count next lands on 0.
- R11: When control bit 3 is 1, a period write changes the active period on the next clock.
- R12: A write with `wr_sel` low loads the control register. A write with `wr_sel` high loads the period register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects control, 1 selects period |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current count |
| evt_zero | output | 1 | One-clock strobe on landing at 0 |
| evt_period | output | 1 | One-clock strobe on landing at the period |
| dir_down | output | 1 | High when the last step went down |

## Verification
A corrupted prescaler count shows up as a wrong spacing between count changes, within one tick interval of at most 1792 clocks. A wrong direction or a wrong active period shows up within one count cycle, as a value outside the expected sawtooth or triangle, or as a strobe in the wrong place. A shadow copy that is promoted at the wrong moment shows up at the very next period strobe, which then lands on the wrong count value. A stop rule that is broken shows up as a count that keeps moving, or that stops away from zero, within a few ticks.

// File: rtl/pwmtb_pkg.sv
// Package: shared counting-mode encoding and control-field positions for the
// PWM time-base. Assumes a 16-bit control word.
package pwmtb_pkg;
    typedef enum logic [1:0] {
        CM_UP   = 2'b00,
        CM_DOWN = 2'b01,
        CM_UPDN = 2'b10,
        CM_HOLD = 2'b11
    } cnt_mode_e;

    localparam int MODE_LSB = 0;
    localparam int IMM_BIT  = 3;
    localparam int DIVB_LSB = 7;
    localparam int DIVA_LSB = 10;
    localparam int RUN_LSB  = 14;
endpackage

// File: rtl/pwmtb_prescaler.sv
// Prescaler: emits a one-clock tick every 2^a * (b ? 2b : 1) clocks.
// Assumes the field values may change at any time. A count that is already
// past the new limit fires a tick at once and starts again from zero.
module pwmtb_prescaler #(
    parameter int A_W = 3,
    parameter int B_W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] div_a,
    input  logic [B_W-1:0] div_b,
    output logic           tick
);
    localparam int MAX_SHIFT = (2 ** A_W) - 1;
    localparam int DIV_W     = MAX_SHIFT + B_W + 2;

    logic [B_W:0]     stage2;
    logic [DIV_W-1:0] div_total;
    logic [DIV_W-1:0] pre_cnt;

    // Combined division ratio from both stages.
    always_comb begin
        stage2    = (div_b == '0) ? {{B_W{1'b0}}, 1'b1} : {div_b, 1'b0};
        div_total = DIV_W'(stage2) << div_a;
        tick      = (pre_cnt >= div_total - 1'b1);
    end

    // Clock counter that restarts after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_cnt <= '0;
        else if (tick) pre_cnt <= '0;
        else           pre_cnt <= pre_cnt + 1'b1;
    end

    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_total > 1) |=> (!tick || div_total == 1));
endmodule

// File: rtl/pwmtb_period.sv
// Period holder: a shadow copy and an active copy. In shadow mode a write
// lands in the shadow copy, which is promoted when the count lands on zero.
// In immediate mode a write updates both copies.
module pwmtb_period #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_prd,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             imm,
    input  logic             cyc_end,
    output logic [CNT_W-1:0] prd_act
);
    logic [CNT_W-1:0] prd_shd;

    // Shadow and active period update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_shd <= '1;
            prd_act <= '1;
        end else if (wr_prd && imm) begin
            prd_shd <= wr_data;
            prd_act <= wr_data;
        end else begin
            if (wr_prd)  prd_shd <= wr_data;
            if (cyc_end) prd_act <= prd_shd;
        end
    end

    assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm && !cyc_end && !wr_prd) |=> $stable(prd_act));
    assert_imm_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_prd && imm) |=> (prd_act == $past(wr_data)));
endmodule

// File: rtl/pwmtb_counter.sv
// Counter: steps the count on each tick according to the mode and the run
// field, tracks the direction of the last step, and raises the landing
// strobes. Assumes the period is the active copy from pwmtb_period.
module pwmtb_counter
    import pwmtb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  cnt_mode_e        mode,
    input  logic [1:0]       run,
    input  logic [CNT_W-1:0] prd,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_dn,
    output logic             evz,
    output logic             evp,
    output logic             cyc_end
);
    logic [CNT_W-1:0] nxt;
    logic             nxt_dir;
    logic             advance;

    // Next count and direction for the current mode.
    always_comb begin
        nxt     = cnt;
        nxt_dir = dir_dn;
        case (mode)
            CM_UP: begin
                nxt     = (cnt >= prd) ? '0 : cnt + 1'b1;
                nxt_dir = 1'b0;
            end
            CM_DOWN: begin
                nxt     = (cnt == '0) ? prd : cnt - 1'b1;
                nxt_dir = 1'b1;
            end
            CM_UPDN: begin
                if (!dir_dn) begin
                    if (cnt >= prd) begin
                        nxt     = (cnt == '0) ? '0 : cnt - 1'b1;
                        nxt_dir = 1'b1;
                    end else begin
                        nxt     = cnt + 1'b1;
                        nxt_dir = 1'b0;
                    end
                end else if (cnt == '0) begin
                    nxt     = (prd == '0) ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
                    nxt_dir = 1'b0;
                end else begin
                    nxt     = cnt - 1'b1;
                    nxt_dir = 1'b1;
                end
            end
            default: begin
                nxt     = cnt;
                nxt_dir = dir_dn;
            end
        endcase
        advance = tick && (mode != CM_HOLD) && (run[1] || (run[0] && cnt != '0));
        cyc_end = advance && (nxt == '0);
    end

    // Count, direction and landing strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            dir_dn <= 1'b0;
            evz    <= 1'b0;
            evp    <= 1'b0;
        end else if (advance) begin
            cnt    <= nxt;
            dir_dn <= nxt_dir;
            evz    <= (nxt == '0);
            evp    <= (nxt == prd);
        end else begin
            evz    <= 1'b0;
            evp    <= 1'b0;
        end
    end

    assert_zero_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evz |-> (cnt == '0));
    assert_down_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_DOWN && tick && run[1]) |=> dir_dn);
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_HOLD) |=> ($stable(cnt) && !evz && !evp));
    assert_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run == 2'b00) |=> $stable(cnt));
    assert_stop_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run == 2'b01 && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/pwm_timebase.sv
// Top: the control register and the write decode, plus the prescaler, the
// period holder and the counter. wr_sel=0 writes control, wr_sel=1 writes
// the period. Assumes CNT_W >= 16, so that the control fields fit.
module pwm_timebase
    import pwmtb_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int A_W   = 3,
    parameter int B_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             evt_zero,
    output logic             evt_period,
    output logic             dir_down
);
    cnt_mode_e        mode_q;
    logic             imm_q;
    logic [A_W-1:0]   diva_q;
    logic [B_W-1:0]   divb_q;
    logic [1:0]       run_q;
    logic             tick;
    logic             cyc_end;
    logic [CNT_W-1:0] prd_act;

    // Control-register fields, loaded on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= CM_UP;
            imm_q  <= 1'b0;
            diva_q <= '0;
            divb_q <= '0;
            run_q  <= 2'b00;
        end else if (wr_en && !wr_sel) begin
            mode_q <= cnt_mode_e'(wr_data[MODE_LSB +: 2]);
            imm_q  <= wr_data[IMM_BIT];
            diva_q <= wr_data[DIVA_LSB +: A_W];
            divb_q <= wr_data[DIVB_LSB +: B_W];
            run_q  <= wr_data[RUN_LSB +: 2];
        end
    end

    pwmtb_prescaler #(.A_W(A_W), .B_W(B_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .div_a(diva_q), .div_b(divb_q), .tick(tick)
    );

    pwmtb_period #(.CNT_W(CNT_W)) u_prd (
        .clk(clk), .rst_n(rst_n), .wr_prd(wr_en && wr_sel), .wr_data(wr_data),
        .imm(imm_q), .cyc_end(cyc_end), .prd_act(prd_act)
    );

    pwmtb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_q), .run(run_q),
        .prd(prd_act), .cnt(count), .dir_dn(dir_down), .evz(evt_zero),
        .evp(evt_period), .cyc_end(cyc_end)
    );
endmodule

// File: tb/sim_pwm_timebase.sv
// Bench: prescaler sweep, a sequence check for each counting mode, the stop
// rules and both period-load policies. All expected values are worked out
// arithmetically.
module sim_pwm_timebase;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] count;
    logic        evt_zero, evt_period, dir_down;

    int checks = 0;
    int fails = 0;

    pwm_timebase u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .count(count), .evt_zero(evt_zero), .evt_period(evt_period), .dir_down(dir_down)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [1:0] run, input logic [2:0] a,
                                       input logic [2:0] b, input logic imm,
                                       input logic [1:0] md);
        return {run, 1'b0, a, b, 3'b000, imm, 1'b0, md};
    endfunction

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_zero(output bit found);
        found = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (evt_zero) begin found = 1'b1; break; end
        end
    endtask

    task automatic wait_prd(output bit found);
        found = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (evt_period) begin found = 1'b1; break; end
        end
    endtask

    // One count cycle per mode, checked step by step after a zero landing.
    task automatic run_seq(input logic [1:0] md, input int p, input string req);
        bit found;
        int c, m, d;
        wr(1'b0, mk(2'b11, 3'd0, 3'd0, 1'b1, md));
        wr(1'b1, 16'(p));
        wait_zero(found);
        chk(found && count == 0, req, int'(count), 0);
        for (int k = 1; k <= 3 * (p + 1); k++) begin
            @(negedge clk);
            if (md == 2'b00) begin
                c = k % (p + 1); d = 0;
            end else if (md == 2'b01) begin
                c = (p + 1 - (k % (p + 1))) % (p + 1); d = 1;
            end else begin
                m = k % (2 * p);
                c = (m <= p) ? m : 2 * p - m;
                d = (m > p || m == 0) ? 1 : 0;
            end
            chk(int'(count) == c && evt_zero == (c == 0) && evt_period == (c == p)
                && int'(dir_down) == d, req, int'(count), c);
        end
    endtask

    // Spacing between count changes for one pair of prescaler fields.
    task automatic meas(input int a, input int b);
        logic [15:0] prev;
        int n, exp;
        wr(1'b0, mk(2'b11, 3'(a), 3'(b), 1'b1, 2'b00));
        prev = count; n = 0;
        while (count == prev && n < 4000) begin @(negedge clk); n++; end
        prev = count; n = 0;
        do begin @(negedge clk); n++; end while (count == prev && n < 4000);
        exp = (1 << a) * ((b == 0) ? 1 : 2 * b);
        chk(n == exp, "R2 prescale", n, exp);
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit found, moved;
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, and the counter stays still.
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(count == 0 && !evt_zero && !evt_period && !dir_down, "R1 reset", int'(count), 0);
        end

        // R2 and R12: prescaler sweep with a long period.
        wr(1'b0, mk(2'b00, 3'd0, 3'd0, 1'b1, 2'b00));
        wr(1'b1, 16'hFFFF);
        for (int a = 0; a < 8; a++) meas(a, 0);
        for (int b = 1; b < 8; b++) meas(0, b);
        meas(2, 3); meas(3, 5); meas(7, 7);

        // R3, R4, R5 and R9: sequences in every counting mode, free run.
        run_seq(2'b00, 1, "R3 up");
        run_seq(2'b00, 6, "R3 up");
        run_seq(2'b01, 3, "R4 down");
        run_seq(2'b01, 6, "R4 down");
        run_seq(2'b10, 1, "R5 updown");
        run_seq(2'b10, 5, "R5 updown");
        run_seq(2'b00, 3, "R9 freerun");

        // R6: the freeze mode holds the count and raises no strobes.
        run_seq(2'b00, 9, "R9 freerun");
        wr(1'b0, mk(2'b11, 3'd0, 3'd0, 1'b1, 2'b11));
        v = count; moved = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (count != v || evt_zero || evt_period) moved = 1'b1;
        end
        chk(!moved, "R6 freeze", int'(count), int'(v));

        // R7: run field 00 halts the counter.
        run_seq(2'b00, 20, "R9 freerun");
        repeat (5) @(negedge clk);
        wr(1'b0, mk(2'b00, 3'd0, 3'd0, 1'b1, 2'b00));
        v = count; moved = 1'b0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (count != v || evt_zero || evt_period) moved = 1'b1;
        end
        chk(!moved, "R7 halt", int'(count), int'(v));

        // R8: run field 01 finishes the cycle and stops on zero.
        wr(1'b0, mk(2'b11, 3'd0, 3'd0, 1'b1, 2'b00));
        wr(1'b1, 16'd9);
        wait_zero(found);
        repeat (3) @(negedge clk);
        wr(1'b0, mk(2'b01, 3'd0, 3'd0, 1'b1, 2'b00));
        found = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (evt_zero) found = 1'b1;
        end
        chk(found && count == 0, "R8 stop at zero", int'(count), 0);
        repeat (6) @(negedge clk);
        chk(count == 0 && !evt_zero, "R8 stays at zero", int'(count), 0);

        // R10: in shadow mode the old period stays until the zero landing.
        wr(1'b0, mk(2'b11, 3'd0, 3'd0, 1'b1, 2'b00));
        wr(1'b1, 16'd9);
        wait_zero(found);
        wr(1'b0, mk(2'b11, 3'd0, 3'd0, 1'b0, 2'b00));
        wr(1'b1, 16'd4);
        wait_prd(found);
        chk(found && count == 9, "R10 shadow keeps old", int'(count), 9);
        wait_prd(found);
        chk(found && count == 4, "R10 shadow promoted", int'(count), 4);

        // R11: in immediate mode the new period applies within the cycle.
        wr(1'b0, mk(2'b11, 3'd0, 3'd0, 1'b1, 2'b00));
        wait_zero(found);
        wr(1'b1, 16'd7);
        wait_prd(found);
        chk(found && count == 7, "R11 immediate", int'(count), 7);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule